// File: doc/BRIEF.md
# Super I/O Indexed Configuration Port

This block is a small register file reached through a pair of byte-wide I/O addresses, by default 0x3F0 and 0x3F1. Software writes a register number to the lower address (the index port) and then reads or writes the selected register through the upper address (the data port). Only the top 32 register numbers, 0xE0 to 0xFF, hold state. Of those, a sparse set is protected and ignores writes. Every register number below 0xE0 reads as zero.

Reset loads a device identifier, a function-select byte with every function off, and base-address codes for a floppy controller, a parallel port and two serial ports. Each base code is exported as a 10-bit I/O address equal to the code shifted left by two. The whole port starts disabled. It is switched on and off by bit 1 of one byte in the host bridge's configuration space, seen here as a configuration write strobe.

I/O requests come in on a valid/ready channel. A read is answered on a valid/ready response channel one cycle after it is accepted. The request side accepts a new request only when no response is waiting, or when the waiting response is being taken in the same cycle. Writes produce no response. A read that is not claimed is still answered, with 0xFF, so the bus never hangs. A read is not claimed when the port is disabled or the address misses.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is disabled and the exported values are: function select 0x03, floppy base 0x3F0, parallel base 0x378, serial-1 base 0x3F8, serial-2 base 0x2F8. Once the port is enabled, register 0xE0 reads 0x3C and the index reads 0.
- R2: A configuration write to address 0x85 sets the port enable to bit 1 of the written byte. Every such write re-evaluates the enable. Configuration writes to any other address leave the enable unchanged.
- R3: While the port is disabled, `req_hit` stays low, reads return 0xFF, and writes change neither the index nor any register.
- R4: A write to address BASE (offset 0) stores the full byte as the index. A read of offset 0 returns the current index.
- R5: A read of offset 1 returns the register selected by the index. Index 0 and every index below 0xE0 read as 0.
- R6: A data-port write stores the byte only for indices 0xE0–0xE3, 0xE6–0xE8, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC. Writes to all other indices are discarded.
- R7: `func_sel` mirrors register 0xE2. The four base outputs are registers 0xE3 (floppy), 0xE6 (parallel), 0xE7 (serial 1) and 0xE8 (serial 2), each shifted left by 2.
- R8: A read accepted at one clock edge raises `rsp_valid` at the next edge. While `rsp_valid` is high and `rsp_ready` is low, `rsp_data` holds and `req_ready` is low.
- R9: Only addresses BASE and BASE+1 are claimed. Reads of any other address return 0xFF, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_valid | input | 1 | Bridge configuration byte write strobe |
| cfg_wr_addr | input | 8 | Bridge configuration byte address |
| cfg_wr_data | input | 8 | Bridge configuration byte data |
| req_valid | input | 1 | I/O request valid |
| req_ready | output | 1 | I/O request accepted when high with valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | I/O byte address |
| req_wdata | input | 8 | Write data |
| req_hit | output | 1 | Current request is claimed by this port |
| rsp_valid | output | 1 | Read response valid |
| rsp_ready | input | 1 | Read response taken |
| rsp_data | output | 8 | Read response byte |
| func_sel | output | 8 | Function-select register |
| fdc_base | output | 10 | Floppy controller I/O base |
| lpt_base | output | 10 | Parallel port I/O base |
| com1_base | output | 10 | Serial port 1 I/O base |
| com2_base | output | 10 | Serial port 2 I/O base |

## Verification
The bench targets the edges of the protection map: 0xE3/0xE4, 0xE8/0xE9, 0xF2/0xF3 and 0xFC/0xFD. A design with a shifted mask would either keep a write that must be discarded or lose one that must land. It checks that reading index 0 through the data port gives 0 and not the stored index, and that writes arriving while the port is off or at a neighbouring address leave no trace. It also holds `rsp_ready` low to show that a response that does not stay put, or a request side that keeps accepting, is caught.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam int unsigned BYTE_W = 8;

  // Power-on contents of the register window, by absolute index.
  function automatic logic [7:0] sio_default(input int unsigned idx);
    case (idx)
      32'hE0:  sio_default = 8'h3C;
      32'hE2:  sio_default = 8'h03;
      32'hE3:  sio_default = 8'hFC;
      32'hE6:  sio_default = 8'hDE;
      32'hE7:  sio_default = 8'hFE;
      32'hE8:  sio_default = 8'hBE;
      default: sio_default = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/sio_port_gate.sv
module sio_port_gate #(
  parameter logic [15:0] BASE    = 16'h03F0,
  parameter logic [7:0]  EN_ADDR = 8'h85,
  parameter int unsigned EN_BIT  = 1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_valid,
  input  logic [7:0]  cfg_wr_addr,
  input  logic [7:0]  cfg_wr_data,
  input  logic [15:0] io_addr,
  output logic        port_en,
  output logic        addr_hit,
  output logic        is_data
);
  always_ff @(posedge clk) begin
    if (!rst_n)                                      port_en <= 1'b0;
    else if (cfg_wr_valid && cfg_wr_addr == EN_ADDR) port_en <= cfg_wr_data[EN_BIT];
  end

  assign addr_hit = port_en && (io_addr[15:1] == BASE[15:1]);
  assign is_data  = io_addr[0];
endmodule

// File: rtl/sio_regbank.sv
module sio_regbank
  import sio_cfg_pkg::*;
#(
  parameter logic [7:0]  WIN_BASE  = 8'hE0,
  parameter int unsigned WIN_DEPTH = 32,
  parameter logic [31:0] WR_MASK   = 32'h1157_C1CF,
  localparam int unsigned AW = $clog2(WIN_DEPTH)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [7:0]                  wr_idx,
  input  logic [7:0]                  wr_data,
  input  logic [7:0]                  rd_idx,
  output logic [7:0]                  rd_data,
  output logic [WIN_DEPTH*BYTE_W-1:0] win_q
);
  logic [7:0] wr_off, rd_off;
  logic       wr_in, rd_in;

  assign wr_off = wr_idx - WIN_BASE;
  assign rd_off = rd_idx - WIN_BASE;
  assign wr_in  = (wr_idx >= WIN_BASE) && (int'(wr_off) < WIN_DEPTH);
  assign rd_in  = (rd_idx >= WIN_BASE) && (int'(rd_off) < WIN_DEPTH);

  for (genvar k = 0; k < WIN_DEPTH; k++) begin : g_cell
    localparam logic [7:0] RST_VAL = sio_default(int'(WIN_BASE) + k);
    if (WR_MASK[k]) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk) begin
        if (!rst_n)                                   q <= RST_VAL;
        else if (wr_en && wr_in && int'(wr_off) == k) q <= wr_data;
      end
      assign win_q[k*BYTE_W +: BYTE_W] = q;
    end else begin : g_ro
      assign win_q[k*BYTE_W +: BYTE_W] = RST_VAL;
    end
  end

  assign rd_data = rd_in ? win_q[rd_off[AW-1:0]*BYTE_W +: BYTE_W] : 8'h00;
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] BASE      = 16'h03F0,
  parameter logic [7:0]  EN_ADDR   = 8'h85,
  parameter int unsigned EN_BIT    = 1,
  parameter logic [7:0]  WIN_BASE  = 8'hE0,
  parameter int unsigned WIN_DEPTH = 32,
  parameter int unsigned ADDR_W    = 10,
  localparam int unsigned FSEL_OFF = 'hE2 - WIN_BASE,
  localparam int unsigned FDC_OFF  = 'hE3 - WIN_BASE,
  localparam int unsigned LPT_OFF  = 'hE6 - WIN_BASE,
  localparam int unsigned COM1_OFF = 'hE7 - WIN_BASE,
  localparam int unsigned COM2_OFF = 'hE8 - WIN_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr_valid,
  input  logic [7:0]        cfg_wr_addr,
  input  logic [7:0]        cfg_wr_data,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [15:0]       req_addr,
  input  logic [7:0]        req_wdata,
  output logic              req_hit,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic [7:0]        func_sel,
  output logic [ADDR_W-1:0] fdc_base,
  output logic [ADDR_W-1:0] lpt_base,
  output logic [ADDR_W-1:0] com1_base,
  output logic [ADDR_W-1:0] com2_base
);
  logic                        port_en, addr_hit, is_data;
  logic [7:0]                  cur_idx, bank_rd;
  logic [WIN_DEPTH*BYTE_W-1:0] win_q;
  logic                        accept, acc_hit;

  sio_port_gate #(.BASE(BASE), .EN_ADDR(EN_ADDR), .EN_BIT(EN_BIT)) u_gate (
    .clk, .rst_n, .cfg_wr_valid, .cfg_wr_addr, .cfg_wr_data,
    .io_addr(req_addr), .port_en, .addr_hit, .is_data
  );

  assign req_ready = !rsp_valid || rsp_ready;
  assign accept    = req_valid && req_ready;
  assign acc_hit   = accept && addr_hit;
  assign req_hit   = req_valid && addr_hit;

  always_ff @(posedge clk) begin
    if (!rst_n)                                  cur_idx <= 8'h00;
    else if (acc_hit && req_write && !is_data)   cur_idx <= req_wdata;
  end

  sio_regbank #(.WIN_BASE(WIN_BASE), .WIN_DEPTH(WIN_DEPTH)) u_bank (
    .clk, .rst_n,
    .wr_en(acc_hit && req_write && is_data),
    .wr_idx(cur_idx), .wr_data(req_wdata),
    .rd_idx(cur_idx), .rd_data(bank_rd), .win_q
  );

  logic [7:0] rd_byte;
  always_comb begin
    if (!acc_hit)          rd_byte = 8'hFF;
    else if (!is_data)     rd_byte = cur_idx;
    else if (cur_idx == 0) rd_byte = 8'h00;
    else                   rd_byte = bank_rd;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= 8'h00;
    end else if (accept && !req_write) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rd_byte;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  function automatic logic [ADDR_W-1:0] to_base(input logic [7:0] code);
    to_base = ADDR_W'({code, 2'b00});
  endfunction

  assign func_sel  = win_q[FSEL_OFF*BYTE_W +: BYTE_W];
  assign fdc_base  = to_base(win_q[FDC_OFF*BYTE_W  +: BYTE_W]);
  assign lpt_base  = to_base(win_q[LPT_OFF*BYTE_W  +: BYTE_W]);
  assign com1_base = to_base(win_q[COM1_OFF*BYTE_W +: BYTE_W]);
  assign com2_base = to_base(win_q[COM2_OFF*BYTE_W +: BYTE_W]);
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cfg_wr_valid,
  input logic [7:0]  cfg_wr_addr,
  input logic [7:0]  cfg_wr_data,
  input logic        req_valid,
  input logic        req_ready,
  input logic        req_write,
  input logic [15:0] req_addr,
  input logic [7:0]  req_wdata,
  input logic        req_hit,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [7:0]  rsp_data,
  input logic [7:0]  func_sel,
  input logic        port_en,
  input logic [7:0]  cur_idx
);
  // R8
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data));
  // R8
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !req_write |=> rsp_valid);
  // R8
  no_accept_when_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !req_ready);
  // R2
  enable_follows_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_valid && cfg_wr_addr == 8'h85 |=> port_en == $past(cfg_wr_data[1]));
  // R3
  no_hit_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en |-> !req_hit);
  // R3
  off_write_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !port_en && !cfg_wr_valid |=> $stable(cur_idx) && $stable(func_sel));
  // R4
  index_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_hit && req_ready && req_write && !req_addr[0] |=> cur_idx == $past(req_wdata));
endmodule

bind sio_cfg_port sio_cfg_port_chk u_sio_cfg_port_chk (
  .clk, .rst_n, .cfg_wr_valid, .cfg_wr_addr, .cfg_wr_data,
  .req_valid, .req_ready, .req_write, .req_addr, .req_wdata, .req_hit,
  .rsp_valid, .rsp_ready, .rsp_data, .func_sel, .port_en, .cur_idx
);

// File: tb/sio_cfg_port_bench.sv
`timescale 1ns/1ps
module sio_cfg_port_bench;
  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic cfg_wr_valid = 0; logic [7:0] cfg_wr_addr = 0, cfg_wr_data = 0;
  logic req_valid = 0, req_write = 0, rsp_ready = 1;
  logic [15:0] req_addr = 0; logic [7:0] req_wdata = 0;
  logic req_ready, req_hit, rsp_valid; logic [7:0] rsp_data, func_sel;
  logic [9:0] fdc_base, lpt_base, com1_base, com2_base;

  sio_cfg_port u_sio_cfg_port (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0] m_reg [256];
  logic [7:0] m_idx; logic m_en;

  function automatic bit can_write(input logic [7:0] i);
    case (i)
      8'hE0, 8'hE1, 8'hE2, 8'hE3, 8'hE6, 8'hE7, 8'hE8,
      8'hEE, 8'hEF, 8'hF0, 8'hF1, 8'hF2, 8'hF4, 8'hF6, 8'hF8, 8'hFC: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [7:0] exp_read(input logic [15:0] a);
    if (!m_en || a[15:1] != 15'h01F8) return 8'hFF;
    if (!a[0]) return m_idx;
    if (m_idx < 8'hE0) return 8'h00;
    return m_reg[m_idx];
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic model_reset();
    foreach (m_reg[i]) m_reg[i] = 8'h00;
    m_reg[8'hE0] = 8'h3C; m_reg[8'hE2] = 8'h03; m_reg[8'hE3] = 8'hFC;
    m_reg[8'hE6] = 8'hDE; m_reg[8'hE7] = 8'hFE; m_reg[8'hE8] = 8'hBE;
    m_idx = 0; m_en = 0;
  endtask

  task automatic cfg_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr_valid = 1; cfg_wr_addr = a; cfg_wr_data = d;
    @(negedge clk); cfg_wr_valid = 0;
    if (a == 8'h85) m_en = d[1];
  endtask

  task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk); req_valid = 0;
    if (m_en && a[15:1] == 15'h01F8) begin
      if (!a[0]) m_idx = d;
      else if (can_write(m_idx)) m_reg[m_idx] = d;
    end
  endtask

  task automatic io_rd(input logic [15:0] a, input string req);
    logic [7:0] e;
    e = exp_read(a);
    @(negedge clk); req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk); req_valid = 0;
    check(req, {15'h0, rsp_valid}, 16'h1);
    check(req, {8'h0, rsp_data}, {8'h0, e});
  endtask

  task automatic check_outs(input string req);
    check(req, {8'h0, func_sel}, {8'h0, m_reg[8'hE2]});
    check(req, {6'h0, fdc_base},  {6'h0, m_reg[8'hE3], 2'b00});
    check(req, {6'h0, lpt_base},  {6'h0, m_reg[8'hE6], 2'b00});
    check(req, {6'h0, com1_base}, {6'h0, m_reg[8'hE7], 2'b00});
    check(req, {6'h0, com2_base}, {6'h0, m_reg[8'hE8], 2'b00});
  endtask

  initial begin
    #200000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5105));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", {6'h0, fdc_base}, 16'h03F0);
    check("R1", {6'h0, lpt_base}, 16'h0378);
    check("R1", {6'h0, com1_base}, 16'h03F8);
    check("R1", {6'h0, com2_base}, 16'h02F8);
    check("R1", {8'h0, func_sel}, 16'h0003);
    // R3 disabled: reads FF, writes ignored
    check("R3", {15'h0, req_hit}, 16'h0);
    io_wr(16'h03F0, 8'hE2); io_wr(16'h03F1, 8'h55);
    io_rd(16'h03F0, "R3"); io_rd(16'h03F1, "R3");
    // R2 enable only through 0x85 bit 1
    cfg_wr(8'h84, 8'hFF); io_rd(16'h03F0, "R2");
    cfg_wr(8'h85, 8'h02); io_rd(16'h03F0, "R2");
    io_rd(16'h03F1, "R5");                       // index 0 reads 0
    io_wr(16'h03F0, 8'hE0); io_rd(16'h03F1, "R1"); io_rd(16'h03F0, "R4");
    // R6 mask boundaries
    for (int i = 0; i < 14; i++) begin
      logic [7:0] ix;
      ix = (i < 10) ? 8'hE2 + 8'(i) : 8'hF1 + 8'(i - 10);
      io_wr(16'h03F0, ix); io_wr(16'h03F1, 8'hA5 ^ ix); io_rd(16'h03F1, "R6");
    end
    io_wr(16'h03F0, 8'hFC); io_wr(16'h03F1, 8'h11); io_rd(16'h03F1, "R6");
    io_wr(16'h03F0, 8'hFD); io_wr(16'h03F1, 8'h11); io_rd(16'h03F1, "R6");
    io_wr(16'h03F0, 8'h10); io_wr(16'h03F1, 8'h11); io_rd(16'h03F1, "R5");
    check_outs("R7");
    // R9 neighbour addresses
    io_wr(16'h03F2, 8'h33); io_rd(16'h03F2, "R9"); io_rd(16'h13F0, "R9");
    io_rd(16'h03F0, "R9");
    // R8 back-pressure
    @(negedge clk); rsp_ready = 0; req_valid = 1; req_write = 0; req_addr = 16'h03F0;
    @(negedge clk); req_valid = 0;
    check("R8", {15'h0, rsp_valid}, 16'h1);
    check("R8", {15'h0, req_ready}, 16'h0);
    check("R8", {8'h0, rsp_data}, {8'h0, m_idx});
    @(negedge clk);
    check("R8", {8'h0, rsp_data}, {8'h0, m_idx});
    rsp_ready = 1;
    @(negedge clk);
    check("R8", {15'h0, rsp_valid}, 16'h0);
    // R2 disable again, R3 writes ignored
    cfg_wr(8'h85, 8'hFD); io_wr(16'h03F0, 8'hE7); io_wr(16'h03F1, 8'h00);
    io_rd(16'h03F1, "R3"); check_outs("R3");
    cfg_wr(8'h85, 8'h02); io_rd(16'h03F0, "R3");
    // random mix
    for (int n = 0; n < 400; n++) begin
      int unsigned op;
      logic [7:0] r;
      op = $urandom_range(0, 9); r = 8'($urandom);
      case (op)
        0, 1: io_wr(16'h03F0, (r[0] ? (8'hE0 | r[4:0]) : r));
        2, 3: io_wr(16'h03F1, r);
        4, 5: io_rd(16'h03F1, "R6");
        6:    io_rd(16'h03F0, "R4");
        7:    cfg_wr(r[0] ? 8'h85 : 8'h86, (r[7:5] == 0) ? 8'h00 : 8'h02);
        8:    io_rd(16'h03F0 + {14'h0, r[1:0]}, "R9");
        default: check_outs("R7");
      endcase
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule